// File: doc/BRIEF.md
# Broadside Predicate Register File

This block holds sixty-four one-bit predicates. Entry 0 is a constant that always reads as 1. Entries 1 to 15 form a static group. Entries 16 to 63 form a rotating group.

Ordinary execution reaches the file through two single-predicate read ports and one single-predicate write port. For these accesses, a logical index in the rotating group is offset by a rotating rename base before it selects a physical entry.

Alongside these sits a bulk path that moves predicates to and from a 64-bit general-register word, where predicate N always pairs with word bit N. The bulk path has three operations:

- a masked load, with one mask bit per static predicate and one shared mask bit for the whole rotating group;
- a load of every rotating predicate from a sign-extended 28-bit immediate;
- a read of the entire file as one word.

All bulk operations address the file as though the rename base were zero.

Each cycle the surrounding pipeline presents one bulk operation code and, at the same time, at most one single-predicate write. Reads are combinational and show the contents held before the coming clock edge. Writes take effect at that edge.

Operation handling is a named selection over four codes:

| Code | Name | Action |
|------|------|--------|
| 2'd0 | IDLE | No bulk action |
| 2'd1 | MASKED | Masked load |
| 2'd2 | ROTIMM | Rotating immediate load |
| 2'd3 | DUMP | Whole-file read |

The file has no sequencing state. Every operation completes in the cycle it is presented, and the only transition is the per-entry update at each clock edge.

Top module: `pred_broadside_file`

## Requirements
- R1: After reset (rst_n low), every predicate from 1 to 63 holds 0, and predicate 0 reads 1.
- R2: Predicate 0 reads 1 on every read port and in bit 0 of the whole-file word. A write aimed at it, single or bulk, leaves it unchanged.
- R3: With bulk_op = 2'd1 (MASKED), the mask gates the load as follows:
  - grp_mask[k], for k from 1 to 15, gates predicate k;
  - grp_mask[0] gates all of predicates 16 to 63 together.
  
  A gated predicate takes bit N of src_word. An ungated predicate keeps its value.
- R4: With bulk_op = 2'd2 (ROTIMM), the rotating predicates load from the immediate:
  - predicates 16 to 42 take rot_imm[0] to rot_imm[26], in order;
  - predicates 43 to 63 all take rot_imm[27];
  - predicates 1 to 15 are unchanged.
- R5: With bulk_op = 2'd3 (DUMP), bit N of bulk_rdata equals predicate N as held before the current edge. With any other code, bulk_rdata is all zeros.
- R6: All bulk operations (codes 1, 2 and 3) address predicates as if rrb were 0, whatever value rrb holds.
- R7: For single-predicate reads and writes, a logical index n below 16 selects entry n. An index of 16 or above selects entry 16 + ((n - 16 + rrb) mod 48), where rrb is always below 48.
- R8: When wr_en is high, wr_val is stored at the renamed entry on the rising clock edge. The read ports and bulk_rdata show the value held before that edge.
- R9: In a cycle with both a bulk write (code 1 or 2) and a single write, the bulk value wins on every entry the bulk write covers. The single write still lands on an entry the bulk write leaves alone.
- R10: The two read ports, rd_idx_a/rd_val_a and rd_idx_b/rd_val_b, are independent, and each is renamed per R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bulk_op | input | 2 | Bulk operation code: 0 IDLE, 1 MASKED, 2 ROTIMM, 3 DUMP |
| src_word | input | 64 | General-register word for the masked load |
| grp_mask | input | 16 | Masked-load gates: bit 0 for the rotating group, bits 1-15 for static predicates |
| rot_imm | input | 28 | Immediate for the rotating load, sign bit 27 |
| rrb | input | 6 | Rotating rename base, below 48 |
| wr_en | input | 1 | Single-predicate write enable |
| wr_idx | input | 6 | Logical index of the single write |
| wr_val | input | 1 | Value for the single write |
| rd_idx_a | input | 6 | Logical index for read port A |
| rd_val_a | output | 1 | Predicate value on port A |
| rd_idx_b | input | 6 | Logical index for read port B |
| rd_val_b | output | 1 | Predicate value on port B |
| bulk_rdata | output | 64 | Whole-file word during DUMP, zero otherwise |

## Verification
A bulk load and a single-predicate write can fall in the same cycle and contend for the same entries. The same is true of a whole-file read and a single write.

The stimulus provokes these collisions in two ways:

- random cycles draw the write enable and the bulk code independently, with a nonzero rename base;
- directed cases aim a single write at a covered rotating entry, and at an uncovered static one, during a masked load.

The bench model settles each collision by applying the single write first and letting the bulk write overwrite the entries it covers. It then compares the model against the whole-file word and both read ports on the following cycle.

// File: rtl/pred_pkg.sv
package pred_pkg;
    parameter int NUM_PRED   = 64;
    parameter int NUM_STATIC = 16;
    parameter int IMM_W      = 28;
    parameter int MASK_W     = 16;
    localparam int IDX_W     = $clog2(NUM_PRED);
    localparam int ROT_CNT   = NUM_PRED - NUM_STATIC;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_MASKED = 2'd1,
        OP_ROTIMM = 2'd2,
        OP_DUMP   = 2'd3
    } bulk_op_e;
endpackage

// File: rtl/pred_rename.sv
module pred_rename
    import pred_pkg::*;
(
    input  logic [IDX_W-1:0] log_idx,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] phys_idx
);
    localparam int OFF_W = IDX_W + 1;

    logic [OFF_W-1:0] off;

    always_comb begin
        off = {1'b0, log_idx} - OFF_W'(NUM_STATIC) + {1'b0, base};
        if (off >= OFF_W'(ROT_CNT)) begin
            off = off - OFF_W'(ROT_CNT);
        end
        if (log_idx < IDX_W'(NUM_STATIC)) begin
            phys_idx = log_idx;
        end else begin
            phys_idx = IDX_W'(off + OFF_W'(NUM_STATIC));
        end
    end
endmodule

// File: rtl/pred_bulk_path.sv
module pred_bulk_path
    import pred_pkg::*;
(
    input  bulk_op_e              op,
    input  logic [NUM_PRED-1:0]   src_word,
    input  logic [MASK_W-1:0]     grp_mask,
    input  logic [IMM_W-1:0]      rot_imm,
    input  logic [NUM_PRED-1:0]   file_q,
    output logic [NUM_PRED-1:0]   bulk_we,
    output logic [NUM_PRED-1:0]   bulk_wd,
    output logic [NUM_PRED-1:0]   bulk_rdata
);
    localparam int EXT_W = ROT_CNT - IMM_W;

    logic [ROT_CNT-1:0] imm_ext;

    assign imm_ext = {{EXT_W{rot_imm[IMM_W-1]}}, rot_imm};

    always_comb begin
        bulk_we    = '0;
        bulk_wd    = '0;
        bulk_rdata = '0;
        unique case (op)
            OP_IDLE: begin
            end
            OP_MASKED: begin
                for (int k = 1; k < NUM_STATIC; k++) begin
                    bulk_we[k] = grp_mask[k];
                end
                bulk_we[NUM_PRED-1:NUM_STATIC] = {ROT_CNT{grp_mask[0]}};
                bulk_wd = src_word;
            end
            OP_ROTIMM: begin
                bulk_we[NUM_PRED-1:NUM_STATIC] = '1;
                bulk_wd[NUM_PRED-1:NUM_STATIC] = imm_ext;
            end
            OP_DUMP: begin
                bulk_rdata = file_q;
            end
            default: begin
            end
        endcase
        bulk_we[0] = 1'b0;
    end
endmodule

// File: rtl/pred_storage.sv
module pred_storage
    import pred_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PRED-1:0]  bulk_we,
    input  logic [NUM_PRED-1:0]  bulk_wd,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_phys,
    input  logic                 wr_val,
    output logic [NUM_PRED-1:0]  file_q
);
    assign file_q[0] = 1'b1;

    for (genvar i = 1; i < NUM_PRED; i++) begin : g_ent
        logic hit;
        logic q;

        assign hit = wr_en && (wr_phys == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (bulk_we[i]) begin
                q <= bulk_wd[i];
            end else if (hit) begin
                q <= wr_val;
            end
        end

        assign file_q[i] = q;
    end
endmodule

// File: rtl/pred_broadside_file.sv
module pred_broadside_file
    import pred_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bulk_op,
    input  logic [63:0]  src_word,
    input  logic [15:0]  grp_mask,
    input  logic [27:0]  rot_imm,
    input  logic [5:0]   rrb,
    input  logic         wr_en,
    input  logic [5:0]   wr_idx,
    input  logic         wr_val,
    input  logic [5:0]   rd_idx_a,
    output logic         rd_val_a,
    input  logic [5:0]   rd_idx_b,
    output logic         rd_val_b,
    output logic [63:0]  bulk_rdata
);
    localparam int NRD = 2;

    logic [NUM_PRED-1:0] file_q;
    logic [NUM_PRED-1:0] bulk_we;
    logic [NUM_PRED-1:0] bulk_wd;
    logic [IDX_W-1:0]    wr_phys;
    logic [IDX_W-1:0]    rd_log  [NRD];
    logic [IDX_W-1:0]    rd_phys [NRD];
    logic                rd_val  [NRD];

    assign rd_log[0] = rd_idx_a;
    assign rd_log[1] = rd_idx_b;
    assign rd_val_a  = rd_val[0];
    assign rd_val_b  = rd_val[1];

    pred_rename u_wr_map (
        .log_idx  (wr_idx),
        .base     (rrb),
        .phys_idx (wr_phys)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        pred_rename u_rd_map (
            .log_idx  (rd_log[p]),
            .base     (rrb),
            .phys_idx (rd_phys[p])
        );
        assign rd_val[p] = file_q[rd_phys[p]];
    end

    pred_bulk_path u_bulk (
        .op         (bulk_op_e'(bulk_op)),
        .src_word   (src_word),
        .grp_mask   (grp_mask),
        .rot_imm    (rot_imm),
        .file_q     (file_q),
        .bulk_we    (bulk_we),
        .bulk_wd    (bulk_wd),
        .bulk_rdata (bulk_rdata)
    );

    pred_storage u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .bulk_we (bulk_we),
        .bulk_wd (bulk_wd),
        .wr_en   (wr_en),
        .wr_phys (wr_phys),
        .wr_val  (wr_val),
        .file_q  (file_q)
    );
endmodule

// File: rtl/pred_broadside_chk.sv
module pred_broadside_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bulk_op,
    input logic [15:0]  grp_mask,
    input logic [27:0]  rot_imm,
    input logic         wr_en,
    input logic [5:0]   rd_idx_a,
    input logic         rd_val_a,
    input logic [63:0]  bulk_rdata,
    input logic [63:0]  file_q
);
    p_zero_reads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == 6'd0) |-> rd_val_a);

    p_dump_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op == 2'd3) |-> bulk_rdata[0]);

    p_quiet_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op != 2'd3) |-> (bulk_rdata == 64'd0));

    p_rot_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op == 2'd2) |=> (file_q[63:43] == {21{$past(rot_imm[27])}}));

    p_rot_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op == 2'd2) |=> (file_q[42:16] == $past(rot_imm[26:0])));

    p_group_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op == 2'd1 && !grp_mask[0] && !wr_en) |=> $stable(file_q[63:16]));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bulk_op[1] == bulk_op[0] && !wr_en) |=> $stable(file_q));
endmodule

bind pred_broadside_file pred_broadside_chk u_chk (.*);

// File: tb/pred_broadside_file_tb.sv
module pred_broadside_file_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bulk_op;
    logic [63:0] src_word;
    logic [15:0] grp_mask;
    logic [27:0] rot_imm;
    logic [5:0]  rrb;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic        wr_val;
    logic [5:0]  rd_idx_a;
    logic [5:0]  rd_idx_b;
    logic        rd_val_a;
    logic        rd_val_b;
    logic [63:0] bulk_rdata;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model;

    always #5 clk = ~clk;

    pred_broadside_file u_dut (
        .clk(clk), .rst_n(rst_n), .bulk_op(bulk_op), .src_word(src_word),
        .grp_mask(grp_mask), .rot_imm(rot_imm), .rrb(rrb), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_val(wr_val), .rd_idx_a(rd_idx_a),
        .rd_val_a(rd_val_a), .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b),
        .bulk_rdata(bulk_rdata)
    );

    function automatic logic [5:0] remap(input logic [5:0] n, input logic [5:0] b);
        int v;
        if (n < 6'd16) return n;
        v = 16 + ((int'(n) - 16 + int'(b)) % 48);
        return 6'(v);
    endfunction

    function automatic logic [63:0] step_model(input logic [63:0] cur);
        logic [63:0] nx;
        logic [5:0]  p;
        nx = cur;
        if (wr_en) begin
            p = remap(wr_idx, rrb);
            nx[p] = wr_val;
        end
        if (bulk_op == 2'd1) begin
            for (int k = 1; k < 16; k++) if (grp_mask[k]) nx[k] = src_word[k];
            if (grp_mask[0]) nx[63:16] = src_word[63:16];
        end else if (bulk_op == 2'd2) begin
            nx[63:16] = {{20{rot_imm[27]}}, rot_imm};
        end
        nx[0] = 1'b1;
        return nx;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        bulk_op = 2'd0; wr_en = 1'b0; src_word = '0; grp_mask = '0;
        rot_imm = '0; wr_idx = '0; wr_val = 1'b0;
    endtask

    // Called just after a negedge with inputs set: check outputs, then clock.
    task automatic cycle(input string req);
        #1;
        check({req, "/R10 port A"}, {63'd0, rd_val_a}, {63'd0, model[remap(rd_idx_a, rrb)]});
        check({req, "/R10 port B"}, {63'd0, rd_val_b}, {63'd0, model[remap(rd_idx_b, rrb)]});
        check({req, "/R5 word"}, bulk_rdata, (bulk_op == 2'd3) ? model : 64'd0);
        @(posedge clk);
        model = step_model(model);
        @(negedge clk);
    endtask

    task automatic dump_check(input string req);
        quiet();
        bulk_op = 2'd3;
        #1;
        check(req, bulk_rdata, model);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 1'b0; quiet(); rrb = '0; rd_idx_a = '0; rd_idx_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = 64'h1;
        dump_check("R1 reset state");

        // R2: writes to predicate 0 have no effect
        rrb = 6'd9; wr_en = 1'b1; wr_idx = 6'd0; wr_val = 1'b0;
        rd_idx_a = 6'd0; rd_idx_b = 6'd0;
        cycle("R2 single write p0");
        quiet(); bulk_op = 2'd1; grp_mask = 16'hFFFF; src_word = 64'h0;
        cycle("R2 bulk zero to p0");
        dump_check("R2 p0 after writes");

        // R6 + R4: rotating load with a nonzero base, sign bit set
        quiet(); rrb = 6'd47; bulk_op = 2'd2; rot_imm = 28'h8A5_3C71;
        cycle("R4 rotimm negative");
        dump_check("R6 R4 unrenamed rotating image");
        quiet(); bulk_op = 2'd2; rot_imm = 28'h7FF_FFFF;
        cycle("R4 rotimm positive");
        dump_check("R4 top group follows sign");

        // R3: masked load, rotating group gated off
        quiet(); rrb = 6'd20; bulk_op = 2'd1; grp_mask = 16'h00AA;
        src_word = 64'h0000_0000_0000_FFFF;
        cycle("R3 masked low only");
        dump_check("R3 R6 masked result");

        // R9: collision covered and uncovered
        quiet(); rrb = 6'd5; bulk_op = 2'd1; grp_mask = 16'h0001;
        src_word = 64'h0F0F_F0F0_1234_0000; wr_en = 1'b1; wr_idx = 6'd30; wr_val = 1'b1;
        cycle("R9 covered entry bulk wins");
        dump_check("R9 covered result");
        quiet(); bulk_op = 2'd1; grp_mask = 16'h0001; src_word = 64'hFFFF_FFFF_FFFF_0000;
        wr_en = 1'b1; wr_idx = 6'd3; wr_val = 1'b1;
        cycle("R9 uncovered static entry");
        dump_check("R9 uncovered result");

        // R7/R8: rename wrap and write visibility
        quiet(); rrb = 6'd40; wr_en = 1'b1; wr_idx = 6'd63; wr_val = 1'b0;
        rd_idx_a = 6'd63; rd_idx_b = 6'd15;
        cycle("R7 R8 write at wrap");
        quiet(); rd_idx_a = 6'd63;
        cycle("R7 R8 read back at wrap");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            rrb      = 6'($urandom % 48);
            bulk_op  = 2'($urandom);
            src_word = {$urandom, $urandom};
            grp_mask = 16'($urandom);
            rot_imm  = 28'($urandom);
            wr_en    = 1'($urandom);
            wr_idx   = 6'($urandom);
            wr_val   = 1'($urandom);
            rd_idx_a = 6'($urandom);
            rd_idx_b = 6'($urandom);
            cycle("R7 R8 R9 random");
        end
        dump_check("R3 R4 R9 final image");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule